// File: doc/BRIEF.md
# Synchronous SRAM Delay Interface

This block sits between a static-RAM memory controller that was built for asynchronous parts and a zero-bus-turnaround synchronous SRAM. The controller presents an address, write data, an active-low output enable and an active-low write enable. The block registers these signals towards the memory and returns read data from a capture register. As a result, every access takes exactly one clock more than a direct connection would. The controller must be programmed for one wait state, and `ctl_wait` marks the cycle in which that wait state falls.

Reads and writes are each sequenced by a small three-state machine. Each machine has a resting state, a first phase and a second phase. A new access is accepted in the resting state, and also during the second phase of the previous access. Consecutive reads, consecutive writes and read/write turnarounds therefore run at one access every two clocks, with no idle cycle between them. The memory data bus is split into an output word, a drive enable and an input word, so that the pad ring can build the tri-state buffer.

Top module: `ssram_delay_if`

## Requirements
- R1: While `rst_n` is low and after its release with no request, `mem_oe_n` and `mem_we_n` are 1 and `ctl_wait` and `mem_dq_oe` are 0.
- R2: A read is requested by `ctl_oe_n`=0 with `ctl_we_n`=1. In the cycle after the accepting edge, `mem_addr` equals the requested address, `mem_oe_n` is 0 and `ctl_wait` is 1.
- R3: In the cycle after that, `ctl_wait` is 0 and `ctl_rdata` holds the word the memory returned while `mem_oe_n` was 0. Read data therefore lags a direct connection by exactly one clock.
- R4: Reads issued back to back, one every two clocks, each return the data of their own address, with none lost and none repeated.
- R5: When no request is present at the end of a read's second phase, `mem_oe_n` returns to 1 in the next cycle.
- R6: A write is requested by `ctl_we_n`=0. In the cycle after the accepting edge, `mem_addr` equals the address, `mem_we_n` is 0, `mem_dq_oe` is 0 and `ctl_wait` is 1.
- R7: In the following cycle, `mem_dq_oe` is 1, `mem_dout` equals the write data captured at the accepting edge, `mem_we_n` is 1 and `ctl_wait` is 0. `mem_dq_oe` is 1 in no other cycle.
- R8: Controller inputs that change during the first phase of an access do not alter that access's memory address, its write data or its read result.
- R9: If `ctl_oe_n` and `ctl_we_n` are both 0, the access is a write. `mem_oe_n` and `mem_we_n` are never both 0.
- R10: A write may directly follow a write or a read, and a read may directly follow a write. Each completes with the R6/R7 or R2/R3 timing, and a read returns data written by a write that precedes it directly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_addr | input | AW | Controller address |
| ctl_wdata | input | DW | Controller write data |
| ctl_oe_n | input | 1 | Controller output enable, active low (read request) |
| ctl_we_n | input | 1 | Controller write enable, active low (write request) |
| ctl_rdata | output | DW | Registered read data to the controller |
| ctl_wait | output | 1 | High during the inserted wait cycle of an access |
| mem_addr | output | AW | Registered SRAM address |
| mem_oe_n | output | 1 | SRAM output enable, active low |
| mem_we_n | output | 1 | SRAM write enable, active low |
| mem_dout | output | DW | Write data towards the SRAM data bus |
| mem_dq_oe | output | 1 | Drive enable for the SRAM data bus |
| mem_din | input | DW | Data read from the SRAM data bus |

## Verification
The bench targets the junctions between accesses. Reads run back to back, where a sequencer that returned to rest between accesses would drop every second read or return the previous word twice. Write-to-read and read-to-write turnarounds follow, where a late data phase would collide with the output enable or write to a stale address. It also changes the address and data during an access's first phase, which catches a design that reloads its registers from live inputs. Finally, it raises both enables together to confirm the write priority, which an unguarded decode would break by asserting both memory strobes.

// File: rtl/ssd_pkg.sv
package ssd_pkg;

    // Read sequencer: resting state plus two access phases
    typedef enum logic [1:0] {
        RD_P0   = 2'd0,
        RD_P1   = 2'd1,
        RD_REST = 2'd2
    } rd_st_e;

    // Write sequencer: resting state plus two access phases
    typedef enum logic [1:0] {
        WR_P0   = 2'd0,
        WR_P1   = 2'd1,
        WR_REST = 2'd2
    } wr_st_e;

endpackage

// File: rtl/ssd_rd_seq.sv
module ssd_rd_seq
    import ssd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic go,
    output logic in_p0,
    output logic in_p1
);

    typedef struct packed {
        rd_st_e st;
    } rd_regs_t;

    rd_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            RD_REST: r_d.st = go ? RD_P0 : RD_REST;
            RD_P0:   r_d.st = RD_P1;
            RD_P1:   r_d.st = go ? RD_P0 : RD_REST;
            default: r_d.st = RD_REST;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st <= RD_REST;
        end else begin
            r_q <= r_d;
        end
    end

    assign in_p0 = (r_q.st == RD_P0);
    assign in_p1 = (r_q.st == RD_P1);

endmodule

// File: rtl/ssd_wr_seq.sv
module ssd_wr_seq
    import ssd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic go,
    output logic in_p0,
    output logic in_p1
);

    typedef struct packed {
        wr_st_e st;
    } wr_regs_t;

    wr_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            WR_REST: r_d.st = go ? WR_P0 : WR_REST;
            WR_P0:   r_d.st = WR_P1;
            WR_P1:   r_d.st = go ? WR_P0 : WR_REST;
            default: r_d.st = WR_REST;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st <= WR_REST;
        end else begin
            r_q <= r_d;
        end
    end

    assign in_p0 = (r_q.st == WR_P0);
    assign in_p1 = (r_q.st == WR_P1);

endmodule

// File: rtl/ssd_mem_port.sv
module ssd_mem_port #(
    parameter int AW = 12,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_go,
    input  logic          wr_go,
    input  logic          rd_p0,
    input  logic          wr_p0,
    input  logic [AW-1:0] ctl_addr,
    input  logic [DW-1:0] ctl_wdata,
    input  logic [DW-1:0] mem_din,
    output logic [DW-1:0] ctl_rdata,
    output logic          ctl_wait,
    output logic [AW-1:0] mem_addr,
    output logic          mem_oe_n,
    output logic          mem_we_n,
    output logic [DW-1:0] mem_dout,
    output logic          mem_dq_oe
);

    typedef struct packed {
        logic [AW-1:0] addr;
        logic          oe_n;
        logic          we_n;
        logic [DW-1:0] wdata;
        logic          dq_oe;
        logic [DW-1:0] rdata;
        logic          wait_c;
    } port_regs_t;

    port_regs_t p_d, p_q;

    always_comb begin
        p_d = p_q;
        // address is loaded once per access, at the accepting edge
        if (rd_go || wr_go) begin
            p_d.addr = ctl_addr;
        end
        // strobes are active only in the first phase
        p_d.oe_n   = ~rd_go;
        p_d.we_n   = ~wr_go;
        p_d.wait_c = rd_go | wr_go;
        // write data captured now, driven one clock later
        if (wr_go) begin
            p_d.wdata = ctl_wdata;
        end
        p_d.dq_oe = wr_p0;
        // read word captured at the end of the first phase
        if (rd_p0) begin
            p_d.rdata = mem_din;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            p_q.addr   <= '0;
            p_q.oe_n   <= 1'b1;
            p_q.we_n   <= 1'b1;
            p_q.wdata  <= '0;
            p_q.dq_oe  <= 1'b0;
            p_q.rdata  <= '0;
            p_q.wait_c <= 1'b0;
        end else begin
            p_q <= p_d;
        end
    end

    assign ctl_rdata = p_q.rdata;
    assign ctl_wait  = p_q.wait_c;
    assign mem_addr  = p_q.addr;
    assign mem_oe_n  = p_q.oe_n;
    assign mem_we_n  = p_q.we_n;
    assign mem_dout  = p_q.wdata;
    assign mem_dq_oe = p_q.dq_oe;

endmodule

// File: rtl/ssram_delay_if.sv
module ssram_delay_if #(
    parameter int AW = 12,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] ctl_addr,
    input  logic [DW-1:0] ctl_wdata,
    input  logic          ctl_oe_n,
    input  logic          ctl_we_n,
    output logic [DW-1:0] ctl_rdata,
    output logic          ctl_wait,
    output logic [AW-1:0] mem_addr,
    output logic          mem_oe_n,
    output logic          mem_we_n,
    output logic [DW-1:0] mem_dout,
    output logic          mem_dq_oe,
    input  logic [DW-1:0] mem_din
);

    logic rd_p0, rd_p1, wr_p0, wr_p1;
    logic accept, rd_go, wr_go;

    // a new access may start at rest or in the second phase of the last one
    assign accept = ~rd_p0 & ~wr_p0;
    // write has priority when both enables are low
    assign wr_go  = accept & ~ctl_we_n;
    assign rd_go  = accept & ~ctl_oe_n & ctl_we_n;

    ssd_rd_seq u_rd (
        .clk   (clk),
        .rst_n (rst_n),
        .go    (rd_go),
        .in_p0 (rd_p0),
        .in_p1 (rd_p1)
    );

    ssd_wr_seq u_wr (
        .clk   (clk),
        .rst_n (rst_n),
        .go    (wr_go),
        .in_p0 (wr_p0),
        .in_p1 (wr_p1)
    );

    ssd_mem_port #(.AW(AW), .DW(DW)) u_port (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_go     (rd_go),
        .wr_go     (wr_go),
        .rd_p0     (rd_p0),
        .wr_p0     (wr_p0),
        .ctl_addr  (ctl_addr),
        .ctl_wdata (ctl_wdata),
        .mem_din   (mem_din),
        .ctl_rdata (ctl_rdata),
        .ctl_wait  (ctl_wait),
        .mem_addr  (mem_addr),
        .mem_oe_n  (mem_oe_n),
        .mem_we_n  (mem_we_n),
        .mem_dout  (mem_dout),
        .mem_dq_oe (mem_dq_oe)
    );

endmodule

// File: rtl/ssd_checker.sv
module ssd_checker #(
    parameter int AW = 12,
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          rd_p1,
    input logic          wr_p1,
    input logic          ctl_wait,
    input logic          mem_oe_n,
    input logic          mem_we_n,
    input logic          mem_dq_oe,
    input logic [DW-1:0] mem_dout
);

    // R1: reset leaves both memory strobes and the wait flag inactive
    p_reset_idle_r1: assert property (@(posedge clk)
        !rst_n |=> (mem_oe_n && mem_we_n && !ctl_wait && !mem_dq_oe));

    // R2 / R6: the wait cycle always carries exactly one memory strobe
    p_wait_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_wait |-> (!mem_oe_n || !mem_we_n));

    // R3: the wait state lasts a single cycle
    p_wait_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_wait |=> !ctl_wait);

    // R3: a read strobe is followed by the read sequencer's second phase
    p_read_phase_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |=> rd_p1);

    // R7: write strobe is followed by the data phase with stable data
    p_data_phase_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |=> (mem_dq_oe && wr_p1 && $stable(mem_dout)));

    // R7: the bus is driven only right after a write strobe
    p_drive_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> $past(!mem_we_n));

    // R9: never read and write strobe together, never drive during a read
    p_strobe_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(!mem_oe_n && !mem_we_n) && !(mem_dq_oe && !mem_oe_n));

endmodule

bind ssram_delay_if ssd_checker #(.AW(AW), .DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_p1     (rd_p1),
    .wr_p1     (wr_p1),
    .ctl_wait  (ctl_wait),
    .mem_oe_n  (mem_oe_n),
    .mem_we_n  (mem_we_n),
    .mem_dq_oe (mem_dq_oe),
    .mem_dout  (mem_dout)
);

// File: tb/ssram_delay_if_tb.sv
module ssram_delay_if_tb;

    localparam int AW = 12;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] ctl_addr = '0;
    logic [DW-1:0] ctl_wdata = '0;
    logic          ctl_oe_n = 1'b1;
    logic          ctl_we_n = 1'b1;
    logic [DW-1:0] ctl_rdata;
    logic          ctl_wait;
    logic [AW-1:0] mem_addr;
    logic          mem_oe_n;
    logic          mem_we_n;
    logic [DW-1:0] mem_dout;
    logic          mem_dq_oe;
    logic [DW-1:0] mem_din;

    int n_checks = 0;
    int n_errors = 0;

    always #10 clk = ~clk;  // 50 MHz

    ssram_delay_if #(.AW(AW), .DW(DW)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctl_addr  (ctl_addr),
        .ctl_wdata (ctl_wdata),
        .ctl_oe_n  (ctl_oe_n),
        .ctl_we_n  (ctl_we_n),
        .ctl_rdata (ctl_rdata),
        .ctl_wait  (ctl_wait),
        .mem_addr  (mem_addr),
        .mem_oe_n  (mem_oe_n),
        .mem_we_n  (mem_we_n),
        .mem_dout  (mem_dout),
        .mem_dq_oe (mem_dq_oe),
        .mem_din   (mem_din)
    );

    // Synchronous SRAM model: flow-through read, write data one clock after strobe
    logic [DW-1:0] model [16];
    logic          pend = 1'b0;
    logic [3:0]    pend_a = '0;

    assign mem_din = mem_oe_n ? '0 : model[mem_addr[3:0]];

    always @(posedge clk) begin
        if (pend && mem_dq_oe) model[pend_a] <= mem_dout;
        pend   <= !mem_we_n;
        pend_a <= mem_addr[3:0];
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic t_idle(input bit check_oe);
        ctl_oe_n = 1'b1;
        ctl_we_n = 1'b1;
        @(posedge clk);
        @(negedge clk);
        if (check_oe) begin
            chk(mem_oe_n == 1'b1, "R5", "oe_n after last read", 32'(mem_oe_n), 32'h1);
            chk(ctl_wait == 1'b0, "R5", "wait when idle", 32'(ctl_wait), 32'h0);
        end
    endtask

    task automatic t_read(input logic [AW-1:0] a, input logic [DW-1:0] exp,
                          input bit disturb, input string req);
        ctl_addr = a;
        ctl_oe_n = 1'b0;
        ctl_we_n = 1'b1;
        @(posedge clk);
        @(negedge clk);
        chk(mem_addr == a, "R2", "read address", 32'(mem_addr), 32'(a));
        chk(mem_oe_n == 1'b0, "R2", "read oe_n", 32'(mem_oe_n), 32'h0);
        chk(ctl_wait == 1'b1, "R2", "read wait", 32'(ctl_wait), 32'h1);
        if (disturb) begin
            ctl_addr = a ^ 12'h001;
            ctl_oe_n = 1'b1;
        end
        @(posedge clk);
        @(negedge clk);
        chk(ctl_wait == 1'b0, "R3", "wait ended", 32'(ctl_wait), 32'h0);
        chk(ctl_rdata == exp, req, "read data", 32'(ctl_rdata), 32'(exp));
        if (disturb)
            chk(mem_addr == a, "R8", "address held", 32'(mem_addr), 32'(a));
    endtask

    task automatic t_write(input logic [AW-1:0] a, input logic [DW-1:0] d,
                           input bit both, input bit disturb, input string req);
        ctl_addr  = a;
        ctl_wdata = d;
        ctl_we_n  = 1'b0;
        ctl_oe_n  = both ? 1'b0 : 1'b1;
        @(posedge clk);
        @(negedge clk);
        chk(mem_addr == a, "R6", "write address", 32'(mem_addr), 32'(a));
        chk(mem_we_n == 1'b0, req, "write we_n", 32'(mem_we_n), 32'h0);
        chk(mem_oe_n == 1'b1, "R9", "oe_n during write", 32'(mem_oe_n), 32'h1);
        chk(mem_dq_oe == 1'b0, "R6", "bus released", 32'(mem_dq_oe), 32'h0);
        chk(ctl_wait == 1'b1, "R6", "write wait", 32'(ctl_wait), 32'h1);
        if (disturb) begin
            ctl_wdata = ~d;
            ctl_addr  = a ^ 12'h002;
            ctl_we_n  = 1'b1;
        end
        @(posedge clk);
        @(negedge clk);
        chk(mem_dq_oe == 1'b1, "R7", "bus driven", 32'(mem_dq_oe), 32'h1);
        chk(mem_dout == d, disturb ? "R8" : "R7", "write data", 32'(mem_dout), 32'(d));
        chk(mem_we_n == 1'b1, "R7", "we_n released", 32'(mem_we_n), 32'h1);
        chk(ctl_wait == 1'b0, "R7", "wait ended", 32'(ctl_wait), 32'h0);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog: actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin : main
        for (int i = 0; i < 16; i++) model[i] = '0;
        repeat (3) @(negedge clk);
        // R1: state during reset
        chk(mem_oe_n == 1'b1 && mem_we_n == 1'b1, "R1", "strobes in reset",
            {30'd0, mem_oe_n, mem_we_n}, 32'h3);
        chk(ctl_wait == 1'b0 && mem_dq_oe == 1'b0, "R1", "wait/drive in reset",
            {30'd0, ctl_wait, mem_dq_oe}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk(mem_oe_n && mem_we_n && !ctl_wait && !mem_dq_oe, "R1", "idle after reset",
            {28'd0, mem_oe_n, mem_we_n, ctl_wait, mem_dq_oe}, 32'hC);

        // R6/R7/R10: back-to-back writes
        t_write(12'h001, 16'hA1A1, 1'b0, 1'b0, "R6");
        t_write(12'h002, 16'hB2B2, 1'b0, 1'b0, "R10");
        t_write(12'h003, 16'hC3C3, 1'b0, 1'b0, "R10");
        t_idle(1'b0);
        chk(mem_dq_oe == 1'b0, "R7", "bus released when idle", 32'(mem_dq_oe), 32'h0);

        // R2/R3/R5: single read then idle
        t_read(12'h001, 16'hA1A1, 1'b0, "R3");
        t_idle(1'b1);

        // R4: back-to-back reads
        t_read(12'h002, 16'hB2B2, 1'b0, "R4");
        t_read(12'h003, 16'hC3C3, 1'b0, "R4");
        t_read(12'h001, 16'hA1A1, 1'b0, "R4");
        t_read(12'h002, 16'hB2B2, 1'b0, "R4");
        t_idle(1'b1);

        // R10: write directly followed by read of the same word, then read->write
        t_write(12'h005, 16'h5E5E, 1'b0, 1'b0, "R10");
        t_read(12'h005, 16'h5E5E, 1'b0, "R10");
        t_write(12'h006, 16'h6D6D, 1'b0, 1'b0, "R10");
        t_read(12'h006, 16'h6D6D, 1'b0, "R10");
        t_idle(1'b1);

        // R8: inputs changed during the first phase are ignored
        t_write(12'h008, 16'h8888, 1'b0, 1'b1, "R6");
        t_idle(1'b0);
        t_read(12'h008, 16'h8888, 1'b1, "R8");
        t_idle(1'b1);
        t_read(12'h00A, 16'h0000, 1'b0, "R8");
        t_idle(1'b0);

        // R9: both enables low means write
        t_write(12'h007, 16'h7777, 1'b1, 1'b0, "R9");
        t_idle(1'b0);
        t_read(12'h007, 16'h7777, 1'b0, "R9");
        t_idle(1'b1);

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule